// File: doc/BRIEF.md
# Discretized Charge Pump State Model

This block is a clocked, purely Boolean model of a charge pump. It is meant for fast event-free simulation and for formal checking of mixed-signal systems, where the analog pump is replaced by a small state machine. Time is discrete: the model advances by exactly one step on each clock cycle where `step_en` is high, and it holds all state on every other cycle.

Two 1-bit controls, a raise request and a lower request, are combined into a pump mode. Exactly one request high makes the pump active in that direction. Both high or both low leave it dormant. The output is a 5-bit code that stands for 32 evenly spaced levels across the supply range.

The machine has settled (DC) states that loop on themselves, and transient (TRAN) states that carry the code one step at a time between operating points. The states are:
- ST_DC_REST: dormant and settled.
- ST_DC_TOP: settled at code 31.
- ST_DC_FLOOR: settled at code 0.
- ST_TR_REST: a one-step transient after the input becomes dormant.
- ST_TR_RISE: a raising path.
- ST_TR_FALL: a lowering path.

The transitions are:
- A change of mode enters the transient for the new mode from any state.
- ST_TR_REST always goes to ST_DC_REST.
- ST_TR_RISE goes to ST_DC_TOP when the code reaches 31.
- ST_TR_FALL goes to ST_DC_FLOOR when the code reaches 0.
- Each DC state stays where it is while the mode is unchanged.

The step interval `lsb_period` sets how many time steps one code step takes.

Top module: `chgpump_fsm_model`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `level_o` to 0 and `settled_o` to 1, in the dormant settled state.
- R2: Mode encoding from {`up_i`,`dn_i`}: 2'b10 means raise, 2'b01 means lower, and 2'b00 or 2'b11 means dormant. While dormant, `level_o` never changes.
- R3: On cycles with `step_en` low, `level_o` and `settled_o` hold, whatever the inputs do.
- R4: Raise mode behaves as follows:
  - On the time step where the mode changes to raise, the code moves up by one at once.
  - After that, the code moves up by one every N time steps, where N is `lsb_period` and a value of 0 counts as 1.
  - The code saturates at 31.
- R5: Lower mode behaves as R4 does, with the code moving down by one and saturating at 0.
- R6: `settled_o` behaves as follows:
  - It is low from the first time step after any mode change.
  - After a change to dormant, it returns high on the next time step.
  - In a raise or lower path, it returns high on the step where a move reaches the rail.
  - If the code was already at the rail when the change was seen, it returns high on the following step.
- R7: In a settled state with the mode unchanged, time steps change neither `level_o` nor `settled_o`.
- R8: A mode change in the middle of a path abandons that path. The new path starts from the current code on the same time step; for example, a lower request seen at code 31 gives 30.
- R9: Mode changes are detected only on time steps. An input change between steps is seen at the next step where `step_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Time-step enable; state advances only when high |
| up_i | input | 1 | Raise request |
| dn_i | input | 1 | Lower request |
| lsb_period | input | PER_W (4) | Time steps per code step (0 treated as 1) |
| level_o | output | LEVEL_W (5) | Quantized output level code |
| settled_o | output | 1 | High in DC states, low in transient states |

## Verification
The bench sweeps step intervals 0 to 4 with long raise and lower runs that hit both rails. Such a design that misses the rails would wrap from 31 to 0 or from 0 to 31, or leave the settled flag low forever. The runs reverse direction in mid-path, switch to dormant with both requests high and with both low, and reach a rail on the same step as a mode change. A design that keeps the old interval count, or waits a full interval before the first move, would show the first move of a new path one or more steps late. Cycles with `step_en` low, during which the inputs toggle, are mixed in throughout. A design that samples inputs outside time steps would move the code on those cycles, or detect a change too early.

// File: rtl/cp_model_pkg.sv
`timescale 1ns/1ps
package cp_model_pkg;

    typedef enum logic [1:0] {
        PUMP_REST  = 2'd0,
        PUMP_RAISE = 2'd1,
        PUMP_LOWER = 2'd2
    } pump_mode_e;

    typedef enum logic [2:0] {
        ST_DC_REST  = 3'd0,
        ST_DC_TOP   = 3'd1,
        ST_DC_FLOOR = 3'd2,
        ST_TR_REST  = 3'd3,
        ST_TR_RISE  = 3'd4,
        ST_TR_FALL  = 3'd5
    } cp_state_e;

endpackage

// File: rtl/cp_input_classifier.sv
`timescale 1ns/1ps
module cp_input_classifier
    import cp_model_pkg::*;
(
    input  logic       up_i,
    input  logic       dn_i,
    output pump_mode_e mode_o
);

    always_comb begin
        unique case ({up_i, dn_i})
            2'b10:   mode_o = PUMP_RAISE;
            2'b01:   mode_o = PUMP_LOWER;
            default: mode_o = PUMP_REST;
        endcase
    end

endmodule

// File: rtl/cp_step_timer.sv
`timescale 1ns/1ps
module cp_step_timer #(
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             restart,
    input  logic             active,
    input  logic [PER_W-1:0] period,
    output logic             due
);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] last_idx;

    assign last_idx = (period == '0) ? '0 : period - 1'b1;
    assign due      = active && (cnt_q >= last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step_en) begin
            if (restart || due) begin
                cnt_q <= '0;
            end else if (active) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4: the interval counter never runs past the programmed interval
    a_r4_interval_bound: assert property (@(posedge clk) disable iff (rst)
        (step_en && active && !restart) |=> (cnt_q <= $past(last_idx)));

endmodule

// File: rtl/cp_level_reg.sv
`timescale 1ns/1ps
module cp_level_reg #(
    parameter int LEVEL_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inc,
    input  logic               dec,
    output logic [LEVEL_W-1:0] level_q
);

    localparam logic [LEVEL_W-1:0] LVL_TOP   = '1;
    localparam logic [LEVEL_W-1:0] LVL_FLOOR = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= LVL_FLOOR;
        end else if (inc && (level_q != LVL_TOP)) begin
            level_q <= level_q + 1'b1;
        end else if (dec && (level_q != LVL_FLOOR)) begin
            level_q <= level_q - 1'b1;
        end
    end

    // R4: raising at the top rail keeps the code at the rail
    a_r4_ceiling: assert property (@(posedge clk) disable iff (rst)
        (inc && level_q == LVL_TOP) |=> (level_q == LVL_TOP));

    // R5: lowering at the bottom rail keeps the code at the rail
    a_r5_floor: assert property (@(posedge clk) disable iff (rst)
        (dec && level_q == LVL_FLOOR) |=> (level_q == LVL_FLOOR));

    // R4/R5: raise and lower are never requested together
    a_r4_exclusive_move: assert property (@(posedge clk) disable iff (rst)
        !(inc && dec));

endmodule

// File: rtl/chgpump_fsm_model.sv
`timescale 1ns/1ps
module chgpump_fsm_model
    import cp_model_pkg::*;
#(
    parameter int LEVEL_W = 5,
    parameter int PER_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic               up_i,
    input  logic               dn_i,
    input  logic [PER_W-1:0]   lsb_period,
    output logic [LEVEL_W-1:0] level_o,
    output logic               settled_o
);

    localparam logic [LEVEL_W-1:0] LVL_TOP      = '1;
    localparam logic [LEVEL_W-1:0] LVL_FLOOR    = '0;
    localparam logic [LEVEL_W-1:0] LVL_NEAR_TOP = {{(LEVEL_W-1){1'b1}}, 1'b0};
    localparam logic [LEVEL_W-1:0] LVL_ONE      = {{(LEVEL_W-1){1'b0}}, 1'b1};

    pump_mode_e mode;
    pump_mode_e mode_q;
    cp_state_e  state_q;
    cp_state_e  state_d;
    logic       in_change;
    logic       restart;
    logic       inc;
    logic       dec;
    logic       due;
    logic       on_path;

    cp_input_classifier u_classify (
        .up_i   (up_i),
        .dn_i   (dn_i),
        .mode_o (mode)
    );

    assign in_change = (mode != mode_q);
    assign on_path   = (state_q == ST_TR_RISE) || (state_q == ST_TR_FALL);

    cp_step_timer #(.PER_W(PER_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .restart (restart),
        .active  (on_path),
        .period  (lsb_period),
        .due     (due)
    );

    cp_level_reg #(.LEVEL_W(LEVEL_W)) u_level (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .dec     (dec),
        .level_q (level_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DC_REST;
            mode_q  <= PUMP_REST;
        end else if (step_en) begin
            state_q <= state_d;
            mode_q  <= mode;
        end
    end

    // Next state and code moves
    always_comb begin
        state_d = state_q;
        inc     = 1'b0;
        dec     = 1'b0;
        restart = 1'b0;
        if (step_en) begin
            if (in_change) begin
                restart = 1'b1;
                unique case (mode)
                    PUMP_RAISE: begin
                        inc     = 1'b1;
                        state_d = ST_TR_RISE;
                    end
                    PUMP_LOWER: begin
                        dec     = 1'b1;
                        state_d = ST_TR_FALL;
                    end
                    default: state_d = ST_TR_REST;
                endcase
            end else begin
                unique case (state_q)
                    ST_TR_REST: state_d = ST_DC_REST;
                    ST_TR_RISE: begin
                        if (level_o == LVL_TOP) begin
                            state_d = ST_DC_TOP;
                        end else if (due) begin
                            inc = 1'b1;
                            if (level_o == LVL_NEAR_TOP) state_d = ST_DC_TOP;
                        end
                    end
                    ST_TR_FALL: begin
                        if (level_o == LVL_FLOOR) begin
                            state_d = ST_DC_FLOOR;
                        end else if (due) begin
                            dec = 1'b1;
                            if (level_o == LVL_ONE) state_d = ST_DC_FLOOR;
                        end
                    end
                    default: state_d = state_q;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_DC_REST, ST_DC_TOP, ST_DC_FLOOR: settled_o = 1'b1;
            default:                            settled_o = 1'b0;
        endcase
    end

    // R3: nothing moves without a time step
    a_r3_freeze: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(level_o) && $stable(settled_o)));

    // R6: a mode change seen on a step clears the settled flag
    a_r6_settle_drop: assert property (@(posedge clk) disable iff (rst)
        (step_en && in_change) |=> !settled_o);

    // R7: a settled state loops on itself while the mode is unchanged
    a_r7_dc_loop: assert property (@(posedge clk) disable iff (rst)
        (step_en && !in_change && settled_o) |=> ($stable(level_o) && settled_o));

    // R5: in lower mode the code never rises
    a_r5_no_rise: assert property (@(posedge clk) disable iff (rst)
        (step_en && mode == PUMP_LOWER) |=> (level_o <= $past(level_o)));

    // R4: in raise mode the code never falls
    a_r4_no_fall: assert property (@(posedge clk) disable iff (rst)
        (step_en && mode == PUMP_RAISE) |=> (level_o >= $past(level_o)));

    // R2: a dormant mode never moves the code
    a_r2_rest_hold: assert property (@(posedge clk) disable iff (rst)
        (step_en && mode == PUMP_REST) |=> $stable(level_o));

    // R6: the top settled state implies the top code
    a_r6_top_rail: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DC_TOP) |-> (level_o == LVL_TOP));

endmodule

// File: tb/tb_chgpump_fsm_model.sv
`timescale 1ns/1ps
module tb_chgpump_fsm_model;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       up  = 1'b0;
    logic       dn  = 1'b0;
    logic [3:0] per = 4'd1;
    logic [4:0] level;
    logic       settled;

    int checks = 0;
    int fails  = 0;

    // reference state, derived from the requirements
    int rlvl, rmode, rcnt, rphase, rset;   // rphase: 0 settled, 1 rise, 2 fall, 3 rest transient

    always #2.5 clk = ~clk;

    chgpump_fsm_model dut (
        .clk        (clk),
        .rst        (rst),
        .step_en    (en),
        .up_i       (up),
        .dn_i       (dn),
        .lsb_period (per),
        .level_o    (level),
        .settled_o  (settled)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int mode_of(input logic u, input logic d);
        if (u && !d) return 1;
        if (d && !u) return 2;
        return 0;
    endfunction

    task automatic ref_reset();
        rlvl = 0; rmode = 0; rcnt = 0; rphase = 0; rset = 1;
    endtask

    task automatic ref_step(input int m);
        int n;
        n = (per == 0) ? 1 : int'(per);
        if (m != rmode) begin
            rmode = m; rcnt = 0; rset = 0;
            if (m == 1) begin
                if (rlvl < 31) rlvl++;
                rphase = 1;
            end else if (m == 2) begin
                if (rlvl > 0) rlvl--;
                rphase = 2;
            end else begin
                rphase = 3;
            end
        end else if (rphase == 3) begin
            rphase = 0; rset = 1;
        end else if (rphase == 1) begin
            if (rlvl == 31) begin
                rphase = 0; rset = 1;
            end else if (rcnt >= n - 1) begin
                rcnt = 0; rlvl++;
                if (rlvl == 31) begin rphase = 0; rset = 1; end
            end else rcnt++;
        end else if (rphase == 2) begin
            if (rlvl == 0) begin
                rphase = 0; rset = 1;
            end else if (rcnt >= n - 1) begin
                rcnt = 0; rlvl--;
                if (rlvl == 0) begin rphase = 0; rset = 1; end
            end else rcnt++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; up = 1'b0; dn = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_reset();
        chk("R1", int'(level), 0, "level after reset");
        chk("R1", int'(settled), 1, "settled after reset");
    endtask

    task automatic do_step(input logic u, input logic d);
        int m;
        bit was_dc;
        m = mode_of(u, d);
        was_dc = (rphase == 0) && (m == rmode);
        @(negedge clk);
        up = u; dn = d; en = 1'b1;
        @(posedge clk);
        #1;
        en = 1'b0;
        ref_step(m);
        if (was_dc)       chk("R7", int'(level), rlvl, "level in settled loop");
        else if (m == 0)  chk("R2", int'(level), rlvl, "level in dormant mode");
        else if (m == 1)  chk("R4", int'(level), rlvl, "level in raise mode");
        else              chk("R5", int'(level), rlvl, "level in lower mode");
        chk("R6", int'(settled), rset, "settled flag");
    endtask

    // toggle inputs on cycles without a time step, then restore them
    task automatic idle_gap(input int cycles, input logic u, input logic d);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            en = 1'b0; up = ~up; dn = (i % 2 == 0) ? ~dn : dn;
        end
        @(negedge clk);
        up = u; dn = d;
        chk("R3", int'(level), rlvl, "level across idle cycles");
        chk("R3", int'(settled), rset, "settled across idle cycles");
    endtask

    task automatic run_all();
        logic [15:0] lfsr;
        // directed: first fall from the top rail and a mid-path reversal
        per = 4'd1;
        do_reset();
        for (int i = 0; i < 33; i++) do_step(1'b1, 1'b0);
        chk("R4", int'(level), 31, "saturated at top");
        chk("R6", int'(settled), 1, "settled at top");
        do_step(1'b0, 1'b1);
        chk("R8", int'(level), 30, "first lower step from 31");
        chk("R8", int'(settled), 0, "transient after reversal");
        do_reset();
        for (int i = 0; i < 5; i++) do_step(1'b1, 1'b0);
        do_step(1'b0, 1'b1);
        chk("R8", int'(level), 4, "reversal at code 5");
        // R9: a change between steps is seen only at the next step
        @(negedge clk);
        up = 1'b1; dn = 1'b1;
        @(negedge clk);
        up = 1'b0; dn = 1'b1;
        chk("R9", int'(level), 4, "no change seen between steps");
        // sweep of step intervals
        for (int p = 0; p <= 4; p++) begin
            per = 4'(p);
            do_reset();
            for (int i = 0; i < 130; i++) do_step(1'b1, 1'b0);
            do_step(1'b1, 1'b0);
            do_step(1'b0, 1'b1);
            do_step(1'b0, 1'b1);
            idle_gap(3, 1'b1, 1'b1);
            for (int i = 0; i < 4; i++) do_step(1'b1, 1'b1);
            do_step(1'b1, 1'b0);
            do_step(1'b1, 1'b0);
            for (int i = 0; i < 130; i++) do_step(1'b0, 1'b1);
            for (int i = 0; i < 3; i++) do_step(1'b0, 1'b0);
            for (int i = 0; i < 3; i++) do_step(1'b0, 1'b1);
            for (int i = 0; i < 3; i++) do_step(1'b1, 1'b1);
            lfsr = 16'hACE1 ^ 16'(p);
            for (int i = 0; i < 300; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (lfsr[7:5] == 3'd0) idle_gap(int'(lfsr[1:0]) + 1, up, dn);
                if (lfsr[4:2] == 3'd0) do_step(lfsr[0], lfsr[1]);
                else                   do_step(up, dn);
            end
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule